// File: doc/BRIEF.md
# Data-Stream Superpage Address Mapper

This block sits in front of a data-stream translation buffer. Each cycle it may take a 43-bit virtual address and the current two-bit processor mode. It decides whether that address falls inside one of two fixed one-to-one superpage windows. A superpage hit bypasses translation: the block returns a 34-bit physical address one cycle later together with a hit pulse. Any other request returns a need-translation pulse, so the caller can send the address to the translation buffer instead.

A small write-only control register holds three settings: an enable for each window and an endian flag. When the endian flag is set, physical address bit 2 is inverted on every data reference. This covers superpage results and also physical addresses coming back from the translation path, which the block passes through on a separate fill channel. A superpage hit is allowed only when the processor mode is kernel.

Top module: `dstream_superpage_mapper`

## Requirements
- R1: After reset, all three control settings are cleared and every registered output is 0. With the settings cleared, every request reports needTlb.
- R2: A cycle with ctlWrEn high loads ctlWrData into the control settings: bit 0 enables the high window, bit 1 enables the low window and bit 2 enables the endian flip. A request presented in the same cycle as a write still uses the old settings. Requests in later cycles use the new ones, and the settings hold while ctlWrEn is low.
- R3: The high window hits when reqVa[42:30] equals 13'h1FFE. It then gives pa[33:30]=0 and pa[29:0]=reqVa[29:0].
- R4: The low window hits when reqVa[42:41] equals 2'b10. It then gives pa[33:0]=reqVa[33:0], and reqVa[40:34] has no effect on the result.
- R5: reqMode is encoded as 00 kernel, 01 executive, 10 supervisor and 11 user. A superpage hit happens only in kernel mode; any other mode reports needTlb.
- R6: A request that hits no enabled window reports needTlb=1 and superpageHit=0, with pa=0.
- R7: While the endian flag is set, pa bit 2 is inverted on superpage hits. In the same state, fillOutPa equals fillPa with bit 2 inverted. While the flag is clear, fillOutPa equals fillPa.
- R8: The outputs are registered. paValid (or fillOutValid) is high exactly one cycle after the cycle in which reqValid (or fillValid) was high. While paValid is high, exactly one of superpageHit and needTlb is high. Both are low when paValid is low.
- R9: The two window enables act independently. An address in a window whose enable is clear reports needTlb, even when the other window is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| ctlWrEn | input | 1 | Write strobe for the control settings |
| ctlWrData | input | 3 | Control value: bit0 high window, bit1 low window, bit2 endian |
| reqValid | input | 1 | A data-stream address is presented |
| reqVa | input | 43 | Virtual address |
| reqMode | input | 2 | Processor mode (00 kernel ... 11 user) |
| fillValid | input | 1 | A translated physical address is presented |
| fillPa | input | 34 | Physical address from the translation path |
| paValid | output | 1 | Result of a request is available |
| pa | output | 34 | Superpage physical address (0 on a miss) |
| superpageHit | output | 1 | Request was mapped through a superpage window |
| needTlb | output | 1 | Request must go to the translation buffer |
| fillOutValid | output | 1 | Fill result is available |
| fillOutPa | output | 34 | Fill address after the endian adjustment |

## Verification
The in-line properties check the following on every cycle: the one-cycle latency of both channels, the hit/need exclusivity, the zero address on a miss, the absence of hits outside kernel mode, the zero upper field of a high-window hit, the fill channel leaving all bits but bit 2 untouched, and the control settings holding between writes. Other behaviours can only be shown by the bench's scenarios, where a behavioural model predicts the exact address. These are: the exact tag values that select each window, the independence of the enables, a write taking effect one request later, and the inversion of bit 2 depending on the endian setting.

// File: rtl/sp_pkg.sv
package sp_pkg;

  typedef enum logic [1:0] {
    MODE_KERNEL = 2'b00,
    MODE_EXEC   = 2'b01,
    MODE_SUPER  = 2'b10,
    MODE_USER   = 2'b11
  } cpuMode_e;

  localparam int CTL_W        = 3;
  localparam int CTL_WIN_HI   = 0;
  localparam int CTL_WIN_LO   = 1;
  localparam int CTL_ENDIAN   = 2;

  // strobes handed from control to datapath each cycle
  typedef struct packed {
    logic winHiAllow;
    logic winLoAllow;
    logic endianFlip;
    logic reqTake;
    logic fillTake;
  } spStrobes_t;

endpackage

// File: rtl/sp_window.sv
module sp_window #(
  parameter int          VA_W    = 43,
  parameter int          PA_W    = 34,
  parameter int          TAG_LO  = 30,
  parameter int unsigned TAG_VAL = 32'h1FFE,
  parameter int          PASS_W  = 30
) (
  input  logic [VA_W-1:0] va,
  output logic            match,
  output logic [PA_W-1:0] mappedPa
);
  localparam int TAG_W = VA_W - TAG_LO;
  localparam logic [TAG_W-1:0] TAG_BITS = TAG_W'(TAG_VAL);

  assign match = (va[VA_W-1:TAG_LO] == TAG_BITS);

  generate
    if (PASS_W < PA_W) begin : g_zeroHigh
      assign mappedPa = {{(PA_W-PASS_W){1'b0}}, va[PASS_W-1:0]};
    end else begin : g_full
      assign mappedPa = va[PA_W-1:0];
    end
    if (PASS_W < TAG_LO) begin : g_ignored
      logic unusedIgnored;
      assign unusedIgnored = ^va[TAG_LO-1:PASS_W];
    end
  endgenerate
endmodule

// File: rtl/sp_ctrl.sv
module sp_ctrl
  import sp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             reqValid,
  input  logic [1:0]       reqMode,
  input  logic             fillValid,
  output spStrobes_t       strobes
);
  logic [CTL_W-1:0] ctlReg;
  logic             isKernel;

  always_ff @(posedge clk) begin
    if (!rstN)        ctlReg <= '0;
    else if (ctlWrEn) ctlReg <= ctlWrData;
  end

  assign isKernel = (cpuMode_e'(reqMode) == MODE_KERNEL);

  always_comb begin
    strobes            = '0;
    strobes.winHiAllow = ctlReg[CTL_WIN_HI] & isKernel;
    strobes.winLoAllow = ctlReg[CTL_WIN_LO] & isKernel;
    strobes.endianFlip = ctlReg[CTL_ENDIAN];
    strobes.reqTake    = reqValid;
    strobes.fillTake   = fillValid;
  end

  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlWrEn |=> $stable(ctlReg));
  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlWrEn |=> ctlReg == $past(ctlWrData));
endmodule

// File: rtl/sp_datapath.sv
module sp_datapath
  import sp_pkg::*;
#(
  parameter int          VA_W       = 43,
  parameter int          PA_W       = 34,
  parameter int          HI_TAG_LO  = 30,
  parameter int unsigned HI_TAG_VAL = 32'h1FFE,
  parameter int          HI_PASS_W  = 30,
  parameter int          LO_TAG_LO  = 41,
  parameter int unsigned LO_TAG_VAL = 32'h2,
  parameter int          ENDIAN_BIT = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  spStrobes_t      strobes,
  input  logic [VA_W-1:0] reqVa,
  input  logic [PA_W-1:0] fillPa,
  output logic            paValid,
  output logic [PA_W-1:0] pa,
  output logic            superpageHit,
  output logic            needTlb,
  output logic            fillOutValid,
  output logic [PA_W-1:0] fillOutPa
);
  localparam logic [PA_W-1:0] FLIP_MASK = PA_W'(1) << ENDIAN_BIT;

  logic            hiMatch, loMatch, hiHit, loHit, anyHit;
  logic [PA_W-1:0] hiPa, loPa, selPa, flipMask;

  sp_window #(
    .VA_W(VA_W), .PA_W(PA_W), .TAG_LO(HI_TAG_LO),
    .TAG_VAL(HI_TAG_VAL), .PASS_W(HI_PASS_W)
  ) u_winHi (.va(reqVa), .match(hiMatch), .mappedPa(hiPa));

  sp_window #(
    .VA_W(VA_W), .PA_W(PA_W), .TAG_LO(LO_TAG_LO),
    .TAG_VAL(LO_TAG_VAL), .PASS_W(PA_W)
  ) u_winLo (.va(reqVa), .match(loMatch), .mappedPa(loPa));

  assign hiHit    = strobes.winHiAllow & hiMatch;
  assign loHit    = strobes.winLoAllow & loMatch;
  assign anyHit   = hiHit | loHit;
  assign selPa    = hiHit ? hiPa : loPa;
  assign flipMask = strobes.endianFlip ? FLIP_MASK : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paValid      <= 1'b0;
      pa           <= '0;
      superpageHit <= 1'b0;
      needTlb      <= 1'b0;
      fillOutValid <= 1'b0;
      fillOutPa    <= '0;
    end else begin
      paValid      <= strobes.reqTake;
      superpageHit <= strobes.reqTake & anyHit;
      needTlb      <= strobes.reqTake & ~anyHit;
      pa           <= (strobes.reqTake && anyHit) ? (selPa ^ flipMask) : '0;
      fillOutValid <= strobes.fillTake;
      fillOutPa    <= strobes.fillTake ? (fillPa ^ flipMask) : '0;
    end
  end

  // R8
  hit_xor_need_chk: assert property (@(posedge clk) disable iff (!rstN)
    paValid |-> (superpageHit ^ needTlb));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !paValid |-> (!superpageHit && !needTlb));
  // R6
  miss_pa_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    needTlb |-> (pa == '0));
endmodule

// File: rtl/dstream_superpage_mapper.sv
module dstream_superpage_mapper
  import sp_pkg::*;
#(
  parameter int VA_W       = 43,
  parameter int PA_W       = 34,
  parameter int HI_TAG_LO  = 30,
  parameter int LO_TAG_LO  = 41,
  parameter int ENDIAN_BIT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             reqValid,
  input  logic [VA_W-1:0]  reqVa,
  input  logic [1:0]       reqMode,
  input  logic             fillValid,
  input  logic [PA_W-1:0]  fillPa,
  output logic             paValid,
  output logic [PA_W-1:0]  pa,
  output logic             superpageHit,
  output logic             needTlb,
  output logic             fillOutValid,
  output logic [PA_W-1:0]  fillOutPa
);
  localparam logic [PA_W-1:0] KEEP_MASK = ~(PA_W'(1) << ENDIAN_BIT);

  spStrobes_t strobes;

  sp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .reqValid(reqValid), .reqMode(reqMode), .fillValid(fillValid),
    .strobes(strobes)
  );

  sp_datapath #(
    .VA_W(VA_W), .PA_W(PA_W), .HI_TAG_LO(HI_TAG_LO), .HI_TAG_VAL(32'h1FFE),
    .HI_PASS_W(HI_TAG_LO), .LO_TAG_LO(LO_TAG_LO), .LO_TAG_VAL(32'h2),
    .ENDIAN_BIT(ENDIAN_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqVa(reqVa), .fillPa(fillPa),
    .paValid(paValid), .pa(pa), .superpageHit(superpageHit), .needTlb(needTlb),
    .fillOutValid(fillOutValid), .fillOutPa(fillOutPa)
  );

  // R8
  req_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> paValid);
  // R8
  req_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !paValid);
  // R5
  kernel_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode != 2'b00) |=> !superpageHit);
  // R3
  hi_window_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqVa[VA_W-1:HI_TAG_LO] == 13'h1FFE) |=>
      (pa[PA_W-1:HI_TAG_LO] == '0));
  // R7
  fill_passthru_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> (fillOutValid && ((fillOutPa ^ $past(fillPa)) & KEEP_MASK) == '0));
endmodule

// File: tb/dstream_superpage_mapper_tb.sv
module dstream_superpage_mapper_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        ctlWrEn;
  logic [2:0]  ctlWrData;
  logic        reqValid;
  logic [42:0] reqVa;
  logic [1:0]  reqMode;
  logic        fillValid;
  logic [33:0] fillPa;
  logic        paValid, superpageHit, needTlb, fillOutValid;
  logic [33:0] pa, fillOutPa;

  always #2.5 clk = ~clk;

  dstream_superpage_mapper u_dut (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .reqValid(reqValid), .reqVa(reqVa), .reqMode(reqMode),
    .fillValid(fillValid), .fillPa(fillPa), .paValid(paValid), .pa(pa),
    .superpageHit(superpageHit), .needTlb(needTlb),
    .fillOutValid(fillOutValid), .fillOutPa(fillOutPa)
  );

  int    checks = 0;
  int    failures = 0;
  string curTag = "R1";

  // behavioural model state
  bit mHi = 0, mLo = 0, mEnd = 0;
  bit          eValid, eHit, eNeed, eFValid;
  logic [33:0] ePa, eFPa;

  task automatic predict();
    bit kern;
    bit hi, lo;
    kern = (reqMode == 2'd0);
    hi = mHi && kern && (reqVa >> 30) == 43'h1FFE;
    lo = mLo && kern && (reqVa >> 41) == 43'h2;
    eValid = reqValid;
    eHit   = reqValid && (hi || lo);
    eNeed  = reqValid && !(hi || lo);
    ePa    = '0;
    if (eHit) begin
      if (hi) ePa = reqVa % (43'd1 << 30);
      else    ePa = reqVa % (43'd1 << 34);
      if (mEnd) ePa[2] = ~ePa[2];
    end
    eFValid = fillValid;
    eFPa    = fillValid ? fillPa : '0;
    if (fillValid && mEnd) eFPa[2] = ~eFPa[2];
    if (!rstN) begin
      mHi = 0; mLo = 0; mEnd = 0;
      eValid = 0; eHit = 0; eNeed = 0; ePa = '0; eFValid = 0; eFPa = '0;
    end else if (ctlWrEn) begin
      mHi = ctlWrData[0]; mLo = ctlWrData[1]; mEnd = ctlWrData[2];
    end
  endtask

  task automatic compare();
    checks++;
    if (paValid !== eValid || superpageHit !== eHit || needTlb !== eNeed ||
        pa !== ePa || fillOutValid !== eFValid || fillOutPa !== eFPa) begin
      failures++;
      $display("FAIL %s: got v=%0b hit=%0b need=%0b pa=%h fv=%0b fpa=%h exp v=%0b hit=%0b need=%0b pa=%h fv=%0b fpa=%h",
               curTag, paValid, superpageHit, needTlb, pa, fillOutValid, fillOutPa,
               eValid, eHit, eNeed, ePa, eFValid, eFPa);
    end
  endtask

  // inputs already set at a negedge; one clock, then compare
  task automatic step();
    @(posedge clk);
    predict();
    @(negedge clk);
    compare();
    ctlWrEn = 0; reqValid = 0; fillValid = 0;
  endtask

  task automatic req(input logic [42:0] va, input logic [1:0] md);
    reqValid = 1; reqVa = va; reqMode = md;
    step();
  endtask

  task automatic wrCtl(input logic [2:0] v);
    ctlWrEn = 1; ctlWrData = v;
    step();
  endtask

  task automatic fill(input logic [33:0] p);
    fillValid = 1; fillPa = p;
    step();
  endtask

  localparam logic [42:0] HI_A = {13'h1FFE, 30'h2ABC_DEF5};
  localparam logic [42:0] LO_A = {2'b10, 7'h00, 34'h3_1234_5674};
  localparam logic [42:0] LO_B = {2'b10, 7'h5A, 34'h3_1234_5674};

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL R8: watchdog expired, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rstN = 0; ctlWrEn = 0; ctlWrData = '0; reqValid = 0; reqVa = '0;
    reqMode = '0; fillValid = 0; fillPa = '0;
    @(negedge clk);
    curTag = "R1";
    ctlWrEn = 1; ctlWrData = 3'b111; reqValid = 1; reqVa = HI_A;
    step(); step();
    rstN = 1;
    req(HI_A, 2'd0);            // R1: cleared settings -> miss
    req(LO_A, 2'd0);
    // R2: write with same-cycle request uses the old value
    curTag = "R2";
    ctlWrEn = 1; ctlWrData = 3'b001; reqValid = 1; reqVa = HI_A; reqMode = 0;
    step();
    req(HI_A, 2'd0);
    step();                     // idle, settings hold
    req(HI_A, 2'd0);
    // R3: high window tag
    curTag = "R3";
    req({13'h1FFE, 30'h0}, 2'd0);
    req({13'h1FFE, 30'h3FFF_FFFF}, 2'd0);
    req({13'h1FFF, 30'h1234}, 2'd0);
    req({13'h1FFC, 30'h1234}, 2'd0);
    // R9: high enable only, low address misses; then low only
    curTag = "R9";
    req(LO_A, 2'd0);
    wrCtl(3'b010);
    req(HI_A, 2'd0);
    req(LO_A, 2'd0);
    // R4: low window, ignored band
    curTag = "R4";
    req(LO_B, 2'd0);
    req({2'b10, 7'h7F, 34'h0}, 2'd0);
    req({2'b11, 41'h1}, 2'd0);
    req({2'b01, 41'h1}, 2'd0);
    // R5: modes
    curTag = "R5";
    wrCtl(3'b011);
    for (int m = 0; m < 4; m++) begin
      req(HI_A, m[1:0]);
      req(LO_A, m[1:0]);
    end
    // R6: miss output zero
    curTag = "R6";
    req(43'h0, 2'd0);
    req({2'b00, 41'h1FF_FFFF_FFFF}, 2'd0);
    // R7: endian flip
    curTag = "R7";
    fill(34'h0_0000_0004);
    wrCtl(3'b111);
    req(HI_A, 2'd0);
    req(LO_A, 2'd0);
    req({13'h1FFE, 30'h0}, 2'd0);
    fill(34'h0_0000_0004);
    fill(34'h3_FFFF_FFFB);
    req(HI_A, 2'd3);
    // R8: back-to-back with fills alongside
    curTag = "R8";
    for (int i = 0; i < 300; i++) begin
      if ($urandom_range(0, 7) == 0) begin
        ctlWrEn = 1; ctlWrData = 3'($urandom_range(0, 7));
      end
      reqValid = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 2))
        0: reqVa = {13'h1FFE, 30'($urandom)};
        1: reqVa = {2'b10, 7'($urandom), 2'($urandom), 32'($urandom)};
        default: reqVa = {11'($urandom), 32'($urandom)};
      endcase
      reqMode = ($urandom_range(0, 1) == 0) ? 2'd0 : 2'($urandom);
      fillValid = $urandom_range(0, 1) == 1;
      fillPa = {2'($urandom), 32'($urandom)};
      step();
    end
    step();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule